// File: doc/BRIEF.md
# Global-History Correlating Branch Predictor

This block guesses the direction of conditional branches from two things: where the branch sits and how the most recent branches went. A small shift register keeps the outcomes of the last few resolved branches, with 1 meaning taken. The current history value picks one counter out of a row of counters, and a few low bits of the branch address pick the row. In the default configuration, two history bits select one of four 2-bit counters per row. The storage is therefore four times that of a single-counter-per-row table with the same number of rows.

The fetch side drives `pred_pc` and reads back `pred_taken` in the same cycle. It also receives `pred_hist`, a snapshot of the history that was used. When the branch resolves, the pipeline returns the address, the real outcome and that snapshot on the resolve port. The block then steps the counter that made the guess and shifts the real outcome into the history. Because the update uses the returned snapshot, any history shifts made in the meantime do not move the update to the wrong counter. Branches whose addresses agree in the index bits share counters (aliasing).

Each counter is a four-state machine: `CNT_SNT` (00), `CNT_WNT` (01), `CNT_WT` (10) and `CNT_ST` (11). A taken resolve moves one state up: SNT to WNT, WNT to WT, WT to ST, and ST stays at ST. A not-taken resolve moves one state down: ST to WT, WT to WNT, WNT to SNT, and SNT stays at SNT. Reset places every counter in `CNT_WNT`.

Top module: `gcorr_predictor`

## Requirements
- R1: After reset the history is 0 and every counter is in state 01, so `pred_taken` is 0 and `pred_hist` is 0 for any address.
- R2: Each cycle with `res_valid` high, the history shifts left by one and `res_taken` enters bit 0 (1 = taken). `pred_hist` shows the new value from the next cycle on.
- R3: `pred_taken` comes from the counter in row `pred_pc[IDX_W+1:2]`, column `pred_hist`, and is 1 when that counter is 10 or 11. It depends combinationally on the current state.
- R4: A resolve moves the selected counter up by one on taken or down by one on not-taken. The counter saturates at 11 and at 00.
- R5: The updated counter is the one in row `res_pc[IDX_W+1:2]`, column `res_hist`, whatever the current history is.
- R6: Addresses that match in bits `[IDX_W+1:2]` share every counter of the row; the other address bits have no effect.
- R7: The counters of one row are independent: training the counter for one history value leaves the other columns of that row unchanged.
- R8: In a cycle with `res_valid` low, neither the history nor any counter changes, whatever `res_pc`, `res_taken` and `res_hist` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History snapshot used for this prediction |
| res_valid | input | 1 | A resolved branch is presented this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_hist | input | HIST_W | Snapshot returned from the prediction |

## Verification
A counter that is stepped wrongly or saturated wrongly shows up only when its most significant bit flips at the wrong time. Each check therefore walks a counter across the taken/not-taken boundary, where a missing step or a missing clamp changes `pred_taken` on the very next lookup. A fault in the history register is visible at `pred_hist` one cycle after the resolve. A wrong row or column index shows up as a prediction from an untrained counter, seen as soon as the history is steered back to the trained value.

// File: rtl/gcp_pkg.sv
package gcp_pkg;

    typedef enum logic [1:0] {
        CNT_SNT = 2'b00,
        CNT_WNT = 2'b01,
        CNT_WT  = 2'b10,
        CNT_ST  = 2'b11
    } cnt_state_e;

    localparam cnt_state_e CNT_INIT = CNT_WNT;

endpackage

// File: rtl/gcp_history.sv
module gcp_history #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist_q
);

    logic [HIST_W-1:0] hist_d;

    generate
        if (HIST_W == 1) begin : g_one
            always_comb hist_d = shift_bit;
        end else begin : g_many
            always_comb hist_d = {hist_q[HIST_W-2:0], shift_bit};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= hist_d;
        end
    end

    // R2: the newest outcome lands in bit 0
    assert_new_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist_q[0] == $past(shift_bit));

    generate
        if (HIST_W > 1) begin : g_chk
            // R2: older outcomes move one place up
            assert_shift_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
                shift_en |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));
        end
    endgenerate

    // R8: no resolve, no history movement
    assert_hist_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/gcp_index.sv
module gcp_index #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 4,
    parameter int HIST_W = 2
) (
    input  logic [IDX_W-1:0]        pc_row,
    input  logic [HIST_W-1:0]       hist,
    output logic [IDX_W+HIST_W-1:0] entry
);

    localparam int ROWS = 1 << IDX_W;

    // row in the high part, history column in the low part
    always_comb entry = {pc_row, hist};

    initial begin
        assert (PC_W > PC_LSB + IDX_W && ROWS > 0) else $error("bad index geometry");
    end

endmodule

// File: rtl/gcp_counter_table.sv
module gcp_counter_table
    import gcp_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic              rd_taken,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic              wr_taken
);

    localparam int ENTRIES = 1 << ADDR_W;

    cnt_state_e tbl_q [ENTRIES];
    cnt_state_e cur_state;
    cnt_state_e nxt_state;

    // state register for all counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl_q[i] <= CNT_INIT;
            end
        end else if (wr_en) begin
            tbl_q[wr_idx] <= nxt_state;
        end
    end

    // next state of the counter being resolved
    always_comb begin
        cur_state = tbl_q[wr_idx];
        nxt_state = cur_state;
        unique case (cur_state)
            CNT_SNT: nxt_state = wr_taken ? CNT_WNT : CNT_SNT;
            CNT_WNT: nxt_state = wr_taken ? CNT_WT  : CNT_SNT;
            CNT_WT:  nxt_state = wr_taken ? CNT_ST  : CNT_WNT;
            CNT_ST:  nxt_state = wr_taken ? CNT_ST  : CNT_WT;
            default: nxt_state = CNT_INIT;
        endcase
    end

    // output decode
    always_comb begin
        unique case (tbl_q[rd_idx])
            CNT_WT, CNT_ST: rd_taken = 1'b1;
            default:        rd_taken = 1'b0;
        endcase
    end

    // R4: clamp at the top
    assert_sat_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && cur_state == CNT_ST) |=> tbl_q[$past(wr_idx)] == CNT_ST);

    // R4: clamp at the bottom
    assert_sat_bot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && cur_state == CNT_SNT) |=> tbl_q[$past(wr_idx)] == CNT_SNT);

    // R4: one step up on taken below the top
    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && cur_state != CNT_ST)
        |=> 2'(tbl_q[$past(wr_idx)]) == 2'(2'($past(cur_state)) + 2'd1));

    // R4: one step down on not-taken above the bottom
    assert_step_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && cur_state != CNT_SNT)
        |=> 2'(tbl_q[$past(wr_idx)]) == 2'(2'($past(cur_state)) - 2'd1));

endmodule

// File: rtl/gcorr_predictor.sv
module gcorr_predictor
    import gcp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 4,
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              res_valid,
    input  logic [PC_W-1:0]   res_pc,
    input  logic              res_taken,
    input  logic [HIST_W-1:0] res_hist
);

    localparam int ADDR_W = IDX_W + HIST_W;

    logic [HIST_W-1:0] ghr_q;
    logic [ADDR_W-1:0] rd_idx;
    logic [ADDR_W-1:0] wr_idx;
    logic              unused_pc_bits;

    assign unused_pc_bits = ^{pred_pc[PC_W-1:PC_LSB+IDX_W], pred_pc[PC_LSB-1:0],
                              res_pc[PC_W-1:PC_LSB+IDX_W],  res_pc[PC_LSB-1:0]};

    gcp_history #(.HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (res_valid),
        .shift_bit (res_taken),
        .hist_q    (ghr_q)
    );

    gcp_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_rd_index (
        .pc_row (pred_pc[PC_LSB +: IDX_W]),
        .hist   (ghr_q),
        .entry  (rd_idx)
    );

    gcp_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_wr_index (
        .pc_row (res_pc[PC_LSB +: IDX_W]),
        .hist   (res_hist),
        .entry  (wr_idx)
    );

    gcp_counter_table #(.ADDR_W(ADDR_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_taken (pred_taken),
        .wr_en    (res_valid),
        .wr_idx   (wr_idx),
        .wr_taken (res_taken)
    );

    assign pred_hist = ghr_q;

    // R1: history is clear in the first cycle after reset
    assert_reset_hist_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> pred_hist == '0);

endmodule

// File: tb/gcorr_predictor_bench.sv
`timescale 1ns/1ps
module gcorr_predictor_bench;

    localparam int PC_W   = 32;
    localparam int IDX_W  = 4;
    localparam int HIST_W = 2;
    localparam logic [31:0] SCR_PC = 32'h0000_003C;  // row 15, used only to steer history

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PC_W-1:0]   pred_pc = '0;
    logic              pred_taken;
    logic [HIST_W-1:0] pred_hist;
    logic              res_valid = 1'b0;
    logic [PC_W-1:0]   res_pc = '0;
    logic              res_taken = 1'b0;
    logic [HIST_W-1:0] res_hist = '0;

    int total = 0;
    int bad = 0;
    int mcnt [64];
    logic [1:0] mghr;

    always #2 clk = ~clk;

    gcorr_predictor #(.PC_W(PC_W), .PC_LSB(2), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_gcorr_predictor (
        .clk (clk), .rst_n (rst_n), .pred_pc (pred_pc), .pred_taken (pred_taken),
        .pred_hist (pred_hist), .res_valid (res_valid), .res_pc (res_pc),
        .res_taken (res_taken), .res_hist (res_hist)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int midx(input logic [31:0] pc, input logic [1:0] h);
        return int'({pc[5:2], h});
    endfunction

    task automatic resolve(input logic [31:0] pc, input bit tk, input logic [1:0] h);
        int i;
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_taken = tk; res_hist = h;
        @(negedge clk);
        res_valid = 1'b0; res_pc = ~pc; res_taken = ~tk; res_hist = ~h;
        i = midx(pc, h);
        if (tk) mcnt[i] = (mcnt[i] == 3) ? 3 : mcnt[i] + 1;
        else    mcnt[i] = (mcnt[i] == 0) ? 0 : mcnt[i] - 1;
        mghr = {mghr[0], tk};
    endtask

    task automatic set_hist(input logic [1:0] h);
        resolve(SCR_PC, h[1], mghr);
        resolve(SCR_PC, h[0], mghr);
    endtask

    task automatic probe(input logic [31:0] pc, input string req);
        bit exp;
        pred_pc = pc;
        #1;
        exp = mcnt[midx(pc, mghr)] >= 2;
        chk(pred_taken == exp, req, int'(pred_taken), int'(exp));
        chk(pred_hist == mghr, req, int'(pred_hist), int'(mghr));
    endtask

    task automatic t_reset();
        for (int p = 0; p < 16; p++) begin
            probe(32'(p * 4), "R1");
            chk(pred_taken == 1'b0, "R1", int'(pred_taken), 0);
        end
        chk(pred_hist == 2'b00, "R1", int'(pred_hist), 0);
    endtask

    task automatic t_history();
        resolve(SCR_PC, 1'b1, mghr);
        #1 chk(pred_hist == 2'b01, "R2", int'(pred_hist), 1);
        resolve(SCR_PC, 1'b0, mghr);
        #1 chk(pred_hist == 2'b10, "R2", int'(pred_hist), 2);
        resolve(SCR_PC, 1'b1, mghr);
        #1 chk(pred_hist == 2'b01, "R2", int'(pred_hist), 1);
        resolve(SCR_PC, 1'b1, mghr);
        #1 chk(pred_hist == 2'b11, "R2", int'(pred_hist), 3);
    endtask

    task automatic t_counter();
        logic [31:0] pa = 32'h0000_0010;  // row 4
        resolve(pa, 1'b1, 2'b00);          // 01 -> 10
        set_hist(2'b00);
        probe(pa, "R3"); chk(pred_taken == 1'b1, "R4", int'(pred_taken), 1);
        resolve(pa, 1'b1, 2'b00);          // 11
        resolve(pa, 1'b1, 2'b00);          // stays 11
        resolve(pa, 1'b0, 2'b00);          // 10
        set_hist(2'b00);
        probe(pa, "R4"); chk(pred_taken == 1'b1, "R4", int'(pred_taken), 1);
        resolve(pa, 1'b0, 2'b00);          // 01
        set_hist(2'b00);
        probe(pa, "R4"); chk(pred_taken == 1'b0, "R4", int'(pred_taken), 0);
        resolve(pa, 1'b0, 2'b00);          // 00
        resolve(pa, 1'b0, 2'b00);          // stays 00
        resolve(pa, 1'b1, 2'b00);          // 01, not 10
        set_hist(2'b00);
        probe(pa, "R4"); chk(pred_taken == 1'b0, "R4", int'(pred_taken), 0);
    endtask

    task automatic t_snapshot();
        logic [31:0] pb = 32'h0000_0020;  // row 8
        set_hist(2'b11);
        resolve(pb, 1'b1, 2'b01);
        set_hist(2'b01);
        probe(pb, "R5"); chk(pred_taken == 1'b1, "R5", int'(pred_taken), 1);
        set_hist(2'b11);
        probe(pb, "R5"); chk(pred_taken == 1'b0, "R5", int'(pred_taken), 0);
    endtask

    task automatic t_alias();
        resolve(32'h0000_0008, 1'b1, 2'b10);  // row 2
        set_hist(2'b10);
        probe(32'h0000_0048, "R6"); chk(pred_taken == 1'b1, "R6", int'(pred_taken), 1);
        probe(32'hABC0_000B, "R6"); chk(pred_taken == 1'b1, "R6", int'(pred_taken), 1);
        probe(32'h0000_000C, "R6"); chk(pred_taken == 1'b0, "R6", int'(pred_taken), 0);
    endtask

    task automatic t_columns();
        logic [31:0] pd = 32'h0000_0030;  // row 12
        resolve(pd, 1'b1, 2'b00);
        resolve(pd, 1'b1, 2'b00);
        for (int h = 1; h < 4; h++) begin
            set_hist(2'(h));
            probe(pd, "R7"); chk(pred_taken == 1'b0, "R7", int'(pred_taken), 0);
        end
        set_hist(2'b00);
        probe(pd, "R7"); chk(pred_taken == 1'b1, "R7", int'(pred_taken), 1);
    endtask

    task automatic t_idle();
        logic [31:0] pe = 32'h0000_0004;  // row 1, untouched
        set_hist(2'b00);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            res_valid = 1'b0; res_pc = pe; res_taken = 1'b1; res_hist = 2'b00;
        end
        probe(pe, "R8"); chk(pred_taken == 1'b0, "R8", int'(pred_taken), 0);
        chk(pred_hist == 2'b00, "R8", int'(pred_hist), 0);
    endtask

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mcnt[i] = 1;
        mghr = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_history();
        t_counter();
        t_snapshot();
        t_alias();
        t_columns();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule